// File: doc/BRIEF.md
# Serial Octal Switch Fault Controller

This block is the digital core of an eight-channel low-side switch that software programs over a four-wire serial link. A frame opens when the chip-select input falls and closes when it rises. During the frame one command bit per channel is shifted in on `si`, and a fault-status byte is shifted out on `so`, most significant channel first. A command bit of one turns its channel off and a command bit of zero turns it on. Per-channel open-load, over-current and over-temperature flags, plus a global over-voltage flag, arrive as digital inputs. The block turns them into the channel enables, the per-channel current-limit requests and the returned status byte.

Status is encoded against the previous command. A healthy channel echoes the bit that was written for it in the last accepted frame. A faulty channel returns the opposite bit. The `limit_mode` input selects how over-current is handled. When it is high the channel keeps running and asks for current limiting. When it is low the channel is shut down and stays latched off until the next accepted frame. Over-voltage drops every channel at once and keeps them latched off until a full frame has been accepted.

The frame sequencer has three states. `ST_IDLE` goes to `ST_SHIFT` when chip select falls, and the status byte is captured on that transition. `ST_SHIFT` goes to `ST_COMMIT` when chip select rises after exactly eight clock rises, and goes back to `ST_IDLE` when it rises after any other count. `ST_COMMIT` applies the received word, clears the latches and returns to `ST_IDLE` unconditionally.

Top module: `octal_sw_ctrl`

## Requirements
- R1: After reset every `out_en` bit is low and the stored command is all ones. A command bit of 1 disables the channel and a command bit of 0 enables it.
- R2: For a channel whose stored command bit is 1, the returned status bit is 0 if `open_load` is high when the frame opens, and 1 otherwise.
- R3: For a channel whose stored command bit is 0, the returned status bit is 1 if `over_cur` or `over_temp` is high when the frame opens, and 0 otherwise.
- R4: With `limit_mode` high, an enabled channel with `over_cur` high stays enabled and drives `cur_limit` high, and the fault is still reported per R3. `cur_limit` is low whenever `limit_mode` is low.
- R5: With `limit_mode` low, `over_cur` on an enabled channel disables it. The channel stays disabled after the flag clears, until the next accepted frame.
- R6: `over_temp` disables only its own channel, and only while the flag is high.
- R7: `over_volt` forces all `out_en` low in the same cycle. They stay low after the flag clears, until a frame is accepted.
- R8: The status byte is captured when chip select falls and is shifted out bit 7 first, with the next bit presented after each `sclk` rise. `so` is low outside a frame.
- R9: A frame updates the command only if exactly 8 `sclk` rises occurred while chip select was low. Shorter and longer frames leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial command data, bit 7 first |
| so | output | 1 | Serial status data, bit 7 first |
| limit_mode | input | 1 | 1: limit current on over-current; 0: latch the channel off |
| over_volt | input | 1 | Supply over-voltage flag |
| open_load | input | 8 | Per-channel open-load flags |
| over_cur | input | 8 | Per-channel over-current flags |
| over_temp | input | 8 | Per-channel over-temperature flags |
| out_en | output | 8 | Per-channel output enables |
| cur_limit | output | 8 | Per-channel current-limit requests |

## Verification
The hardest case to reach is a latch that outlives its cause. An over-current shutdown or an over-voltage drop must still hold after the flag has cleared, and must only be released by a frame of the right length. The stimulus raises and clears each flag between frames and checks the enables in that gap. It then sends seven-bit and nine-bit frames, which must not release the latch, and finally a proper frame that must. A behavioural model in the bench tracks the latches and the frame counter and compares every output on every clock.

// File: rtl/octal_sw_pkg.sv
package octal_sw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/octal_sw_status.sv
module octal_sw_status #(
    parameter int N_CH = 8
) (
    input  logic [N_CH-1:0] cmd_q,
    input  logic [N_CH-1:0] open_load,
    input  logic [N_CH-1:0] over_cur,
    input  logic [N_CH-1:0] over_temp,
    output logic [N_CH-1:0] status_word
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // off channel: flip to 0 on open load; on channel: flip to 1 on heat or current
        assign status_word[i] = cmd_q[i] ? ~open_load[i] : (over_cur[i] | over_temp[i]);
    end
endmodule

// File: rtl/octal_sw_frame.sv
module octal_sw_frame
    import octal_sw_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            si,
    input  logic [N_CH-1:0] status_word,
    output logic            so,
    output logic            commit,
    output logic [N_CH-1:0] rx_word
);
    localparam int CNT_W = $clog2(N_CH) + 2;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_CH);
    localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

    frame_state_t    state, state_nx;
    logic            sclk_q;
    logic            sclk_rise;
    logic [N_CH-1:0] shreg;
    logic [CNT_W-1:0] cnt;

    assign sclk_rise = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!cs_n) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_n)  state_nx = (cnt == CNT_FULL) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            shreg  <= '1;
            cnt    <= '0;
        end else begin
            sclk_q <= sclk;
            if (state == ST_IDLE && !cs_n) begin
                shreg <= status_word;
                cnt   <= '0;
            end else if (state == ST_SHIFT && !cs_n && sclk_rise) begin
                shreg <= {shreg[N_CH-2:0], si};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        so      = (state == ST_SHIFT) ? shreg[N_CH-1] : 1'b0;
        commit  = (state == ST_COMMIT);
        rx_word = shreg;
    end

    p_commit_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> (cnt == CNT_FULL));
    p_so_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so);
endmodule

// File: rtl/octal_sw_gate.sv
module octal_sw_gate #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [N_CH-1:0] new_cmd,
    input  logic            limit_mode,
    input  logic            over_volt,
    input  logic [N_CH-1:0] over_cur,
    input  logic [N_CH-1:0] over_temp,
    output logic [N_CH-1:0] cmd_q,
    output logic [N_CH-1:0] out_en,
    output logic [N_CH-1:0] cur_limit
);
    logic [N_CH-1:0] oc_lat;
    logic            ov_lat;
    logic [N_CH-1:0] oc_trip;

    assign oc_trip = over_cur & ~cmd_q & {N_CH{~limit_mode}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '1;
            oc_lat <= '0;
            ov_lat <= 1'b0;
        end else begin
            ov_lat <= over_volt | (ov_lat & ~commit);
            if (commit) begin
                cmd_q  <= new_cmd;
                oc_lat <= '0;
            end else begin
                oc_lat <= oc_lat | oc_trip;
            end
        end
    end

    always_comb begin
        out_en    = ~cmd_q & ~over_temp & ~oc_lat & ~oc_trip
                  & {N_CH{~(ov_lat | over_volt)}};
        cur_limit = out_en & over_cur & {N_CH{limit_mode}};
    end

    p_ov_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        over_volt |-> (out_en == '0));
    p_ov_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(over_volt) |-> (out_en == '0));
    p_ot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en & over_temp) == '0);
    p_limit_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_mode |-> (cur_limit == '0));
    p_off_when_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en & cmd_q) == '0);
endmodule

// File: rtl/octal_sw_ctrl.sv
module octal_sw_ctrl #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            si,
    output logic            so,
    input  logic            limit_mode,
    input  logic            over_volt,
    input  logic [N_CH-1:0] open_load,
    input  logic [N_CH-1:0] over_cur,
    input  logic [N_CH-1:0] over_temp,
    output logic [N_CH-1:0] out_en,
    output logic [N_CH-1:0] cur_limit
);
    logic [N_CH-1:0] cmd_q;
    logic [N_CH-1:0] status_word;
    logic [N_CH-1:0] rx_word;
    logic            commit;

    octal_sw_status #(.N_CH(N_CH)) u_status (
        .cmd_q       (cmd_q),
        .open_load   (open_load),
        .over_cur    (over_cur),
        .over_temp   (over_temp),
        .status_word (status_word)
    );

    octal_sw_frame #(.N_CH(N_CH)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .si          (si),
        .status_word (status_word),
        .so          (so),
        .commit      (commit),
        .rx_word     (rx_word)
    );

    octal_sw_gate #(.N_CH(N_CH)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .new_cmd    (rx_word),
        .limit_mode (limit_mode),
        .over_volt  (over_volt),
        .over_cur   (over_cur),
        .over_temp  (over_temp),
        .cmd_q      (cmd_q),
        .out_en     (out_en),
        .cur_limit  (cur_limit)
    );
endmodule

// File: tb/octal_sw_ctrl_tb.sv
`timescale 1ns/100ps
module octal_sw_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic limit_mode = 1'b0, over_volt = 1'b0;
    logic [7:0] open_load = '0, over_cur = '0, over_temp = '0;
    logic so;
    logic [7:0] out_en, cur_limit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    octal_sw_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .so(so),
        .limit_mode(limit_mode), .over_volt(over_volt), .open_load(open_load),
        .over_cur(over_cur), .over_temp(over_temp), .out_en(out_en),
        .cur_limit(cur_limit)
    );

    // behavioural reference model
    logic [7:0] m_cmd, m_oc, m_sh;
    logic       m_ov, m_sq;
    int         m_mode;   // 0 idle, 1 in frame, 2 apply pending
    int         m_bits;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 8'hFF; m_oc = '0; m_ov = 0; m_sq = 0;
            m_sh = 8'hFF; m_bits = 0; m_mode = 0;
        end else begin
            logic [7:0] stat;
            bit apply;
            apply = (m_mode == 2);
            for (int i = 0; i < 8; i++)
                stat[i] = m_cmd[i] ? !open_load[i] : (over_cur[i] || over_temp[i]);
            m_ov = over_volt || (m_ov && !apply);
            if (apply) begin
                m_oc = '0;
                m_cmd = m_sh;
                m_mode = 0;
            end else begin
                m_oc = m_oc | (limit_mode ? 8'h00 : (over_cur & ~m_cmd));
                if (m_mode == 0) begin
                    if (!cs_n) begin m_mode = 1; m_sh = stat; m_bits = 0; end
                end else if (cs_n) begin
                    m_mode = (m_bits == 8) ? 2 : 0;
                end else if (sclk && !m_sq) begin
                    m_sh = {m_sh[6:0], si};
                    if (m_bits < 15) m_bits++;
                end
            end
            m_sq = sclk;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] e_en, e_lim;
            e_en  = ~m_cmd & ~over_temp & ~m_oc
                  & (limit_mode ? 8'hFF : ~over_cur) & ((m_ov || over_volt) ? 8'h00 : 8'hFF);
            e_lim = e_en & over_cur & (limit_mode ? 8'hFF : 8'h00);
            chk("R1/R5/R6/R7 out_en model", out_en, e_en);
            chk("R4 cur_limit model", cur_limit, e_lim);
            chk("R8 so model", {7'd0, so}, {7'd0, (m_mode == 1) ? m_sh[7] : 1'b0});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nbits, output logic [7:0] rx);
        rx = '0;
        cs_n = 0;
        cyc(2);
        for (int k = 0; k < nbits; k++) begin
            si = (k < 8) ? cmd[7-k] : 1'b0;
            sclk = 0;
            cyc(2);
            if (k < 8) rx[7-k] = so;
            sclk = 1;
            cyc(2);
        end
        sclk = 0;
        cyc(2);
        cs_n = 1;
        cyc(4);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        cyc(3);
        chk("R1 reset out_en", out_en, 8'h00);
        chk("R4 reset cur_limit", cur_limit, 8'h00);
        chk("R8 reset so", {7'd0, so}, 8'h00);
        rst_n = 1;
        cyc(2);

        xfer(8'hA5, 8, rx);
        chk("R2 echo of reset command", rx, 8'hFF);
        chk("R1 enables follow command", out_en, 8'h5A);

        open_load = 8'h81; over_cur = 8'h02; limit_mode = 1;
        cyc(2);
        chk("R4 limited channel stays on", out_en, 8'h5A);
        chk("R4 limit request", cur_limit, 8'h02);
        xfer(8'hA5, 8, rx);
        chk("R2/R3/R8 fault word", rx, 8'h26);

        open_load = 0; over_cur = 8'h08; limit_mode = 0;
        cyc(2);
        chk("R5 shutdown on over-current", out_en, 8'h52);
        chk("R4 no limit in shutdown mode", cur_limit, 8'h00);
        over_cur = 0;
        cyc(3);
        chk("R5 latch holds after clear", out_en, 8'h52);
        over_temp = 8'h40;
        cyc(2);
        chk("R6 heat drops one channel", out_en, 8'h12);
        over_temp = 0;
        cyc(2);
        chk("R6 heat recovery", out_en, 8'h52);
        xfer(8'hA5, 8, rx);
        chk("R3 healthy echo", rx, 8'hA5);
        chk("R5 latch released by frame", out_en, 8'h5A);

        xfer(8'h00, 7, rx);
        chk("R9 short frame ignored", out_en, 8'h5A);
        xfer(8'h00, 9, rx);
        chk("R9 long frame ignored", out_en, 8'h5A);

        over_volt = 1;
        cyc(1);
        chk("R7 over-voltage drop", out_en, 8'h00);
        over_volt = 0;
        cyc(3);
        chk("R7 latched after clear", out_en, 8'h00);
        xfer(8'h0F, 7, rx);
        chk("R7/R9 short frame keeps latch", out_en, 8'h00);
        xfer(8'h0F, 8, rx);
        chk("R7 released by full frame", out_en, 8'hF0);

        over_temp = 8'h10;
        cyc(2);
        chk("R6 heat on channel 4", out_en, 8'hE0);
        xfer(8'h0F, 8, rx);
        chk("R3 heat reported high", rx, 8'h1F);
        over_temp = 0;
        cyc(2);
        chk("R6 recovered", out_en, 8'hF0);
        chk("R8 idle so low", {7'd0, so}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule